// File: doc/BRIEF.md
# Key Snapshot Event Generator with Ghost Rejection

This block turns one snapshot of a keyboard matrix scan into a serial stream of key events. A snapshot carries up to eight entry bytes and a pending count. Each byte holds a valid flag and the row and column of one key that is held down. The block compares the keys of a new snapshot with the last set of keys it accepted. It emits a release event for every key that has disappeared, then a press event for every key now down, and closes the stream with a sync marker. After the sync it keeps the new set as the reference for the next snapshot.

Two optional treatments apply before any event is produced. When the ghost filter is on, a snapshot with three or more keys is thrown away whole if some pair of its keys shares a row and some pair (not necessarily the same one) shares a column. Such a pattern is the signature of phantom keys in an undiode matrix. When the function layer is on and one of the keys equals the configured layer scancode, that key is withheld from the stream and every other key of the snapshot is moved up by the matrix key count. A snapshot whose pending count is zero means all keys are up: every stored key is released and the stored set becomes empty.

Events leave one per cycle through a valid/ready handshake. A busy flag stays high from the cycle after a snapshot is taken until its sync marker has been transferred, and snapshots are refused while it is high.

Top module: `key_snapshot_events`

## Requirements
- R1: Entry k of a snapshot occupies bits [8k+7:8k] of `snap_entries`. Bit 7 is the valid flag, bits 6:3 the row and bits 2:0 the column. The plain scancode of a key is row*8 + column.
- R2: Only entries with the valid flag set are collected, in increasing entry index. Press events of an accepted snapshot appear in that order, and the row and column bits of invalid entries have no effect.
- R3: For each key of the stored set that is absent from the new set, a release event (`ev_press`=0, `ev_sync`=0) is emitted in stored order, and all releases come before the first press.
- R4: Every key of an accepted snapshot produces a press event (`ev_press`=1), including keys already held. The stream ends with exactly one sync event (`ev_sync`=1, `ev_press`=0, `ev_code`=0).
- R5: With `ghost_en`=1 and three or more collected keys, if any two keys share a row and any two keys share a column, the snapshot produces no event at all, not even a sync, and the stored set is kept unchanged.
- R6: With `ghost_en`=0, or when only rows or only columns coincide, a snapshot with shared rows or columns is accepted normally.
- R7: With `fn_en`=1, a collected key whose plain scancode equals `fn_code` is removed and not counted for the ghost check. If it was present, 128 (16 rows times 8 columns) is added to the scancode of every remaining key, both in the press events and in the stored set. With `fn_en`=0 the key is treated like any other.
- R8: A snapshot with `snap_pending`=0 ignores its entries. It releases every stored key, emits a sync and leaves the stored set empty, so a second such snapshot emits only a sync.
- R9: While `ev_valid`=1 and `ev_ready`=0, the event payload is held unchanged. Exactly one event is transferred per cycle in which both are high.
- R10: A snapshot is taken when `snap_valid`=1 and `busy`=0. `busy` rises in the next cycle and falls right after the sync transfer or after a ghost rejection, and a `snap_valid` pulse while `busy`=1 is ignored.
- R11: After reset `busy`=0, `ev_valid`=0 and the stored set is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snap_valid | input | 1 | Snapshot strobe |
| snap_entries | input | 64 | Eight entry bytes, entry 0 in the low byte |
| snap_pending | input | 4 | Pending key count, zero means all keys released |
| ghost_en | input | 1 | Enable ghost rejection |
| fn_en | input | 1 | Enable function-layer translation |
| fn_code | input | 7 | Plain scancode of the function-layer key |
| busy | output | 1 | Snapshot in progress |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Consumer accepts the event |
| ev_code | output | 8 | Scancode of the event |
| ev_press | output | 1 | 1 for press, 0 for release |
| ev_sync | output | 1 | End-of-snapshot marker |

## Verification
On every cycle the assertions check the handshake: a stalled event is held stable, no event appears while idle, and a taken strobe raises busy. They also check that a sync transfer or a ghost rejection returns the block to idle without a stray event, and that the sync marker carries no code. The content of the stream can only be shown by the bench's scenarios. Those scenarios cover which keys are released, the order of presses, the ghost pattern against the single-axis overlap, and the function-layer offset. They also show that a rejected snapshot leaves the stored set intact, which becomes visible only when the next snapshot's releases come out.

// File: rtl/kev_pkg.sv
package kev_pkg;
  localparam int KEV_ROW_W       = 4;
  localparam int KEV_COL_W       = 3;
  localparam int KEV_ENTRIES     = 8;
  localparam int KEV_RAW_W       = KEV_ROW_W + KEV_COL_W;
  localparam int KEV_ENT_W       = KEV_RAW_W + 1;
  localparam int KEV_CODE_W      = KEV_RAW_W + 1;
  localparam int KEV_MATRIX_KEYS = 1 << KEV_RAW_W;

  typedef logic [KEV_RAW_W-1:0]  raw_code_t;
  typedef logic [KEV_CODE_W-1:0] key_code_t;
  typedef logic [KEV_ENT_W-1:0]  entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVAL,
    ST_REL,
    ST_PRESS,
    ST_SYNC
  } kev_state_t;

  function automatic logic ent_valid(input entry_t e);
    return e[KEV_ENT_W-1];
  endfunction

  function automatic logic [KEV_ROW_W-1:0] row_of(input raw_code_t c);
    return c[KEV_RAW_W-1:KEV_COL_W];
  endfunction

  function automatic logic [KEV_COL_W-1:0] col_of(input raw_code_t c);
    return c[KEV_COL_W-1:0];
  endfunction

  // row in the upper field, column in the lower one
  function automatic raw_code_t ent_code(input entry_t e);
    return {e[KEV_RAW_W-1:KEV_COL_W], e[KEV_COL_W-1:0]};
  endfunction

  function automatic key_code_t layer_code(input raw_code_t c, input logic shifted);
    return key_code_t'(c) + (shifted ? key_code_t'(KEV_MATRIX_KEYS) : key_code_t'(0));
  endfunction
endpackage

// File: rtl/kev_collect.sv
module kev_collect
  import kev_pkg::*;
#(
  parameter int NUM_ENT = KEV_ENTRIES,
  localparam int CNT_W = $clog2(NUM_ENT + 1),
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic [NUM_ENT*KEV_ENT_W-1:0] ents,
  input  logic                         fn_en,
  input  raw_code_t                    fn_code,
  output raw_code_t                    codes [NUM_ENT],
  output logic [CNT_W-1:0]             cnt,
  output logic                         fn_hit
);
  always_comb begin
    for (int k = 0; k < NUM_ENT; k++) codes[k] = '0;
    cnt    = '0;
    fn_hit = 1'b0;
    for (int k = 0; k < NUM_ENT; k++) begin
      if (ent_valid(ents[k*KEV_ENT_W +: KEV_ENT_W])) begin
        if (fn_en && ent_code(ents[k*KEV_ENT_W +: KEV_ENT_W]) == fn_code) begin
          fn_hit = 1'b1;
        end else begin
          codes[cnt[IDX_W-1:0]] = ent_code(ents[k*KEV_ENT_W +: KEV_ENT_W]);
          cnt = cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kev_ghost.sv
module kev_ghost
  import kev_pkg::*;
#(
  parameter int NUM_ENT = KEV_ENTRIES,
  localparam int CNT_W = $clog2(NUM_ENT + 1)
) (
  input  raw_code_t        codes [NUM_ENT],
  input  logic [CNT_W-1:0] cnt,
  input  logic             en,
  output logic             row_pair,
  output logic             col_pair,
  output logic             ghost
);
  always_comb begin
    row_pair = 1'b0;
    col_pair = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      for (int j = i + 1; j < NUM_ENT; j++) begin
        if (j < int'(cnt)) begin
          if (row_of(codes[i]) == row_of(codes[j])) row_pair = 1'b1;
          if (col_of(codes[i]) == col_of(codes[j])) col_pair = 1'b1;
        end
      end
    end
    ghost = en && (cnt >= CNT_W'(3)) && row_pair && col_pair;
  end
endmodule

// File: rtl/kev_match.sv
module kev_match
  import kev_pkg::*;
#(
  parameter int NUM_ENT = KEV_ENTRIES,
  localparam int CNT_W = $clog2(NUM_ENT + 1)
) (
  input  key_code_t        probe,
  input  key_code_t        list [NUM_ENT],
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_ENT; k++) begin
      if (k < int'(cnt) && list[k] == probe) hit = 1'b1;
    end
  end
endmodule

// File: rtl/key_snapshot_events.sv
module key_snapshot_events
  import kev_pkg::*;
#(
  parameter int NUM_ENT = KEV_ENTRIES,
  localparam int CNT_W = $clog2(NUM_ENT + 1),
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         snap_valid,
  input  logic [NUM_ENT*KEV_ENT_W-1:0] snap_entries,
  input  logic [CNT_W-1:0]             snap_pending,
  input  logic                         ghost_en,
  input  logic                         fn_en,
  input  logic [KEV_RAW_W-1:0]         fn_code,
  output logic                         busy,
  output logic                         ev_valid,
  input  logic                         ev_ready,
  output logic [KEV_CODE_W-1:0]        ev_code,
  output logic                         ev_press,
  output logic                         ev_sync
);
  kev_state_t                   state;
  logic [NUM_ENT*KEV_ENT_W-1:0] ent_q;
  logic                         ghost_en_q, fn_en_q;
  raw_code_t                    fn_code_q;
  key_code_t                    new_q [NUM_ENT];
  key_code_t                    old_q [NUM_ENT];
  logic [CNT_W-1:0]             new_cnt_q, old_cnt_q, idx_q;

  raw_code_t        col_codes [NUM_ENT];
  logic [CNT_W-1:0] col_cnt;
  logic             col_fn;
  logic             row_pair, col_pair, col_ghost;
  logic             rel_hit;
  logic [IDX_W-1:0] idx_lo;

  // named internal events
  logic snap_take, ghost_drop, commit;

  assign idx_lo     = idx_q[IDX_W-1:0];
  assign busy       = (state != ST_IDLE);
  assign snap_take  = (state == ST_IDLE) && snap_valid;
  assign ghost_drop = (state == ST_EVAL) && col_ghost;
  assign commit     = (state == ST_SYNC) && ev_ready;

  kev_collect #(.NUM_ENT(NUM_ENT)) u_collect (
    .ents    (ent_q),
    .fn_en   (fn_en_q),
    .fn_code (fn_code_q),
    .codes   (col_codes),
    .cnt     (col_cnt),
    .fn_hit  (col_fn)
  );

  kev_ghost #(.NUM_ENT(NUM_ENT)) u_ghost (
    .codes    (col_codes),
    .cnt      (col_cnt),
    .en       (ghost_en_q),
    .row_pair (row_pair),
    .col_pair (col_pair),
    .ghost    (col_ghost)
  );

  kev_match #(.NUM_ENT(NUM_ENT)) u_match (
    .probe (old_q[idx_lo]),
    .list  (new_q),
    .cnt   (new_cnt_q),
    .hit   (rel_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ent_q      <= '0;
      ghost_en_q <= 1'b0;
      fn_en_q    <= 1'b0;
      fn_code_q  <= '0;
      new_cnt_q  <= '0;
      old_cnt_q  <= '0;
      idx_q      <= '0;
      for (int k = 0; k < NUM_ENT; k++) begin
        new_q[k] <= '0;
        old_q[k] <= '0;
      end
    end else begin
      case (state)
        ST_IDLE: begin
          if (snap_take) begin
            ent_q      <= (snap_pending == '0) ? '0 : snap_entries;
            ghost_en_q <= ghost_en;
            fn_en_q    <= fn_en;
            fn_code_q  <= fn_code;
            state      <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (ghost_drop) begin
            state <= ST_IDLE;
          end else begin
            for (int k = 0; k < NUM_ENT; k++) new_q[k] <= layer_code(col_codes[k], col_fn);
            new_cnt_q <= col_cnt;
            idx_q     <= '0;
            state     <= ST_REL;
          end
        end
        ST_REL: begin
          if (idx_q == old_cnt_q) begin
            idx_q <= '0;
            state <= ST_PRESS;
          end else if (rel_hit || ev_ready) begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_PRESS: begin
          if (idx_q == new_cnt_q) state <= ST_SYNC;
          else if (ev_ready) idx_q <= idx_q + 1'b1;
        end
        ST_SYNC: begin
          if (commit) begin
            for (int k = 0; k < NUM_ENT; k++) old_q[k] <= new_q[k];
            old_cnt_q <= new_cnt_q;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ev_valid = 1'b0;
    ev_code  = '0;
    ev_press = 1'b0;
    ev_sync  = 1'b0;
    case (state)
      ST_REL: begin
        if (idx_q != old_cnt_q) begin
          ev_valid = !rel_hit;
          ev_code  = old_q[idx_lo];
        end
      end
      ST_PRESS: begin
        if (idx_q != new_cnt_q) begin
          ev_valid = 1'b1;
          ev_code  = new_q[idx_lo];
          ev_press = 1'b1;
        end
      end
      ST_SYNC: begin
        ev_valid = 1'b1;
        ev_sync  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/kev_checker.sv
module kev_checker
  import kev_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  snap_valid,
  input logic                  busy,
  input logic                  ev_valid,
  input logic                  ev_ready,
  input logic [KEV_CODE_W-1:0] ev_code,
  input logic                  ev_press,
  input logic                  ev_sync,
  input logic                  ghost_drop
);
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_press) && $stable(ev_sync));

  a_r10_take_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid && !busy |=> busy);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ev_valid);

  a_r4_sync_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_sync |=> !busy);

  a_r4_sync_bare: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |-> !ev_press && ev_code == '0);

  a_r5_ghost_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ghost_drop |=> !busy && !ev_valid);
endmodule

bind key_snapshot_events kev_checker u_kev_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .snap_valid (snap_valid),
  .busy       (busy),
  .ev_valid   (ev_valid),
  .ev_ready   (ev_ready),
  .ev_code    (ev_code),
  .ev_press   (ev_press),
  .ev_sync    (ev_sync),
  .ghost_drop (ghost_drop)
);

// File: tb/sim_key_snapshot_events.sv
`timescale 1ns/1ps
module sim_key_snapshot_events;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snap_valid = 1'b0;
  logic [63:0] snap_entries = '0;
  logic [3:0]  snap_pending = '0;
  logic        ghost_en = 1'b0;
  logic        fn_en = 1'b0;
  logic [6:0]  fn_code = '0;
  logic        busy, ev_valid, ev_press, ev_sync;
  logic        ev_ready = 1'b1;
  logic [7:0]  ev_code;

  int n_checks = 0;
  int n_fails  = 0;
  bit stall    = 1'b0;
  int got[$];
  int model_old[$];

  always #10 clk = ~clk;

  key_snapshot_events u0 (
    .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .snap_entries(snap_entries),
    .snap_pending(snap_pending), .ghost_en(ghost_en), .fn_en(fn_en), .fn_code(fn_code),
    .busy(busy), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_code(ev_code),
    .ev_press(ev_press), .ev_sync(ev_sync)
  );

  // ready changes shortly after the active edge
  always @(posedge clk) begin
    #3;
    ev_ready = stall ? ~ev_ready : 1'b1;
  end

  // event monitor and R9 hold check
  bit held = 1'b0;
  int held_ev = 0;
  always @(negedge clk) begin
    if (held) begin
      n_checks++;
      if (!ev_valid || ({ev_sync, ev_press, ev_code} != held_ev[9:0])) begin
        n_fails++;
        $display("FAIL R9 stalled event changed: actual valid=%0b ev=%0h expected %0h",
                 ev_valid, {ev_sync, ev_press, ev_code}, held_ev);
      end
    end
    held = ev_valid && !ev_ready;
    held_ev = int'({ev_sync, ev_press, ev_code});
    if (ev_valid && ev_ready) got.push_back(int'({ev_sync, ev_press, ev_code}));
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  function automatic logic [7:0] ent(input int r, input int c);
    return {1'b1, 4'(r), 3'(c)};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bench model of one snapshot, then drive and compare
  task automatic run_snap(input string tag, input logic [7:0] e [8], input int pend,
                          input bit gf, input bit fe, input int fc);
    int raw[$];
    int nw[$];
    int exp[$];
    bit fhit = 0;
    bit rowp = 0;
    bit colp = 0;
    int guard = 0;
    if (pend != 0) begin
      for (int k = 0; k < 8; k++) begin
        if (e[k][7]) begin
          int code = int'(e[k][6:3]) * 8 + int'(e[k][2:0]);
          if (fe && code == fc) fhit = 1;
          else raw.push_back(code);
        end
      end
    end
    for (int i = 0; i < raw.size(); i++)
      for (int j = i + 1; j < raw.size(); j++) begin
        if (raw[i] / 8 == raw[j] / 8) rowp = 1;
        if (raw[i] % 8 == raw[j] % 8) colp = 1;
      end
    if (!(gf && raw.size() >= 3 && rowp && colp)) begin
      foreach (raw[i]) nw.push_back(raw[i] + (fhit ? 128 : 0));
      foreach (model_old[i]) begin
        bit found = 0;
        foreach (nw[j]) if (nw[j] == model_old[i]) found = 1;
        if (!found) exp.push_back(model_old[i]);
      end
      foreach (nw[i]) exp.push_back(nw[i] | 256);
      exp.push_back(512);
      model_old = nw;
    end
    // drive
    got.delete();
    while (busy) @(negedge clk);
    for (int k = 0; k < 8; k++) snap_entries[k*8 +: 8] = e[k];
    snap_pending = 4'(pend);
    ghost_en = gf;
    fn_en = fe;
    fn_code = 7'(fc);
    snap_valid = 1'b1;
    @(negedge clk);
    snap_valid = 1'b0;
    while (busy && guard < 500) begin
      @(negedge clk);
      guard++;
    end
    check({tag, " event count"}, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      check({tag, " event"}, got[i], exp[i]);
  endtask

  task automatic t_reset();
    check("R11 busy after reset", int'(busy), 0);
    check("R11 ev_valid after reset", int'(ev_valid), 0);
  endtask

  task automatic t_single();
    logic [7:0] e [8] = '{ent(2,5), 0, 0, 0, 0, 0, 0, 0};
    run_snap("R1 R4 single key", e, 1, 0, 0, 0);
  endtask

  task automatic t_order();
    logic [7:0] e [8] = '{8'h3F, ent(1,0), 8'h7F, ent(6,3), 0, 0, 0, 0};
    run_snap("R2 R3 entry order and release", e, 2, 0, 0, 0);
  endtask

  task automatic t_held();
    logic [7:0] e [8] = '{ent(6,3), ent(9,4), ent(1,0), 0, 0, 0, 0, 0};
    run_snap("R4 held keys pressed again", e, 3, 0, 0, 0);
  endtask

  task automatic t_ghost();
    logic [7:0] e [8] = '{ent(1,1), ent(1,2), ent(3,1), 0, 0, 0, 0, 0};
    run_snap("R5 ghost rejected", e, 3, 1, 0, 0);
    check("R5 busy clears after rejection", int'(busy), 0);
  endtask

  task automatic t_row_only();
    logic [7:0] e [8] = '{ent(5,0), ent(5,1), ent(5,2), 0, 0, 0, 0, 0};
    run_snap("R5 R6 row-only overlap accepted, stored set kept", e, 3, 1, 0, 0);
  endtask

  task automatic t_filter_off();
    logic [7:0] e [8] = '{ent(1,1), ent(1,2), ent(3,1), 0, 0, 0, 0, 0};
    run_snap("R6 filter off", e, 3, 0, 0, 0);
  endtask

  task automatic t_fn_layer();
    logic [7:0] e [8] = '{ent(0,7), ent(0,1), ent(4,7), 0, 0, 0, 0, 0};
    run_snap("R7 fn layer offset", e, 3, 1, 1, 7);
  endtask

  task automatic t_fn_off();
    logic [7:0] e [8] = '{ent(0,7), ent(0,1), 0, 0, 0, 0, 0, 0};
    run_snap("R7 fn layer disabled", e, 2, 0, 0, 7);
  endtask

  task automatic t_stall_busy();
    logic [7:0] e [8] = '{ent(15,7), 0, 0, 0, 0, 0, 0, 0};
    stall = 1'b1;
    fork
      run_snap("R9 R10 stalled stream", e, 1, 0, 0, 0);
      begin
        repeat (3) @(negedge clk);
        check("R10 busy during stream", int'(busy), 1);
        snap_entries = {56'h0, ent(3,3)};
        snap_valid = 1'b1;
        @(negedge clk);
        snap_valid = 1'b0;
      end
    join
    stall = 1'b0;
    got.delete();
    repeat (4) @(negedge clk);
    check("R10 strobe while busy ignored (busy)", int'(busy), 0);
    check("R10 strobe while busy ignored (events)", got.size(), 0);
  endtask

  task automatic t_release_all();
    logic [7:0] e [8] = '{ent(2,2), ent(7,1), 0, 0, 0, 0, 0, 0};
    run_snap("R8 release all", e, 0, 0, 0, 0);
    run_snap("R8 release all on empty set", e, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_order();
    t_held();
    t_ghost();
    t_row_only();
    t_filter_off();
    t_fn_layer();
    t_fn_off();
    t_stall_busy();
    t_release_all();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule